// File: doc/BRIEF.md
# SD Host Status and Interrupt Register Pair

This block holds the event/error status word and the configuration word of an SD card host controller. The command engine and the data engine report single-cycle event pulses. Each pulse sets a sticky flag in the status word. Software reads the flags over a small valid/ready register bus. It acknowledges flags by writing ones to their positions: write-one-to-clear.

The configuration word does two jobs. It enables three interrupt sources: data available, block done and busy end. Those sources are combined into one level-sensitive interrupt line. The same word also carries three static datapath settings: a wide internal bus, a 4-bit card bus and slow-card timing. These settings leave the block as plain outputs.

Two summary outputs report error state. One reports any data-path error. The other reports any error at all, which adds the command timeout. The error flags never drive the interrupt line.

Top module: `sdh_stat_irq`

## Requirements
- R1: After synchronous reset, the following are all 0: the status word, the configuration word, the interrupt line and the three datapath setting outputs.
- R2: An event pulse sets its status bit at the next clock edge, and the bit stays set after the pulse ends. The bit positions are: 0 data available, 3 FIFO error, 4 CRC7 error, 5 CRC16 error, 6 command timeout, 7 data timeout, 9 block done, 10 busy end.
- R3: A write to the status word (word address 0) clears every defined bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFFFF clears all flags.
- R4: When an event and a software clear of the same bit fall in the same cycle, the bit stays set. A clear of a different bit in that cycle still takes effect.
- R5: Status bits 1, 2, 8 and 11 to 15, and all bits above 15, always read as 0. Writes to those bits have no effect.
- R6: The configuration word (word address 1) keeps only bits 1, 2, 3, 4, 8 and 10, and all other bits read as 0. Bit 1 drives the wide-bus output, bit 2 the 4-bit card bus output and bit 3 the slow-card output. The word changes only when it is written.
- R7: The interrupt line equals (status 0 AND config 4) OR (status 9 AND config 8) OR (status 10 AND config 10). It follows the registered state with no added delay.
- R8: Error flags (status bits 3 to 7) never assert the interrupt line, whatever the configuration.
- R9: The data-error output is the OR of status bits 3, 4, 5 and 7. The any-error output is the same OR with bit 6 added.
- R10: Ready equals valid on every access. A read returns the addressed word in the same cycle. Other addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_ready_o | output | 1 | Access accepted |
| bus_rdata_o | output | DATA_W | Read data, valid while a read is accepted |
| ev_data_avail_i | input | 1 | Data available event |
| ev_fifo_err_i | input | 1 | FIFO error event |
| ev_crc7_err_i | input | 1 | Response CRC error event |
| ev_crc16_err_i | input | 1 | Data CRC error event |
| ev_cmd_tmo_i | input | 1 | Command timeout event |
| ev_dat_tmo_i | input | 1 | Data timeout event |
| ev_blk_done_i | input | 1 | Block done event |
| ev_busy_end_i | input | 1 | Busy end event |
| irq_o | output | 1 | Level interrupt |
| cfg_wide_o | output | 1 | Wide internal bus setting |
| cfg_nib_o | output | 1 | 4-bit card bus setting |
| cfg_slow_o | output | 1 | Slow-card setting |
| err_data_o | output | 1 | Any data-path error flagged |
| err_any_o | output | 1 | Any error flagged |

## Verification
The bench walks all 256 combinations of the eight events. After each combination it applies a partial clear whose pattern includes undefined bits. A bit map that is off by one, or a clear that hits undefined positions, therefore shows up at once in the read-back.

The bench sweeps all 64 pairings of enables and interrupt sources, each with error flags also set. A design that masked with the wrong configuration bit, or let errors reach the line, would raise a wrong interrupt.

An event and a clear of the same bit are driven in the same cycle. A design where the clear has priority would lose that event.

Reads and writes to an unmapped address are checked against both words. A loose address decode would alias one of the words and would show up there.

// File: rtl/sdh_stat_irq.sv
module sdh_stat_irq #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int STAT_ADDR = 0,
  parameter int CFG_ADDR  = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_ready_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ev_data_avail_i,
  input  logic              ev_fifo_err_i,
  input  logic              ev_crc7_err_i,
  input  logic              ev_crc16_err_i,
  input  logic              ev_cmd_tmo_i,
  input  logic              ev_dat_tmo_i,
  input  logic              ev_blk_done_i,
  input  logic              ev_busy_end_i,
  output logic              irq_o,
  output logic              cfg_wide_o,
  output logic              cfg_nib_o,
  output logic              cfg_slow_o,
  output logic              err_data_o,
  output logic              err_any_o
);
  localparam int          PAD_W     = DATA_W - 16;
  localparam logic [15:0] STAT_MASK = 16'h06F9;
  localparam logic [15:0] CFG_MASK  = 16'h051E;
  localparam logic [15:0] DERR_MASK = 16'h00B8;
  localparam logic [15:0] AERR_MASK = 16'h00F8;

  logic [15:0] stat_q, cfg_q, ev_vec, clr_vec, rd_word;
  logic        wr_stat, wr_cfg;

  assign ev_vec = {5'b0, ev_busy_end_i, ev_blk_done_i, 1'b0,
                   ev_dat_tmo_i, ev_cmd_tmo_i, ev_crc16_err_i, ev_crc7_err_i,
                   ev_fifo_err_i, 2'b0, ev_data_avail_i};

  assign wr_stat = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(STAT_ADDR));
  assign wr_cfg  = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(CFG_ADDR));
  assign clr_vec = wr_stat ? (bus_wdata_i[15:0] & STAT_MASK) : 16'h0000;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stat_q <= '0;
      cfg_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | ev_vec;
      if (wr_cfg) cfg_q <= bus_wdata_i[15:0] & CFG_MASK;
    end
  end

  always_comb begin
    rd_word = 16'h0000;
    if (bus_valid_i && !bus_write_i) begin
      if (bus_addr_i == ADDR_W'(STAT_ADDR))     rd_word = stat_q;
      else if (bus_addr_i == ADDR_W'(CFG_ADDR)) rd_word = cfg_q;
    end
  end

  assign bus_ready_o = bus_valid_i;
  assign bus_rdata_o = {{PAD_W{1'b0}}, rd_word};

  assign irq_o = (stat_q[0] & cfg_q[4]) | (stat_q[9] & cfg_q[8]) | (stat_q[10] & cfg_q[10]);

  assign cfg_wide_o = cfg_q[1];
  assign cfg_nib_o  = cfg_q[2];
  assign cfg_slow_o = cfg_q[3];
  assign err_data_o = |(stat_q & DERR_MASK);
  assign err_any_o  = |(stat_q & AERR_MASK);
endmodule

module sdh_stat_irq_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int STAT_ADDR = 0,
  parameter int CFG_ADDR  = 1
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              bus_ready_o,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [15:0]       ev_vec,
  input logic [15:0]       stat_q,
  input logic [15:0]       cfg_q,
  input logic              irq_o,
  input logic              err_data_o,
  input logic              err_any_o
);
  logic ck_wr_stat, ck_wr_cfg, ck_rd_stat;
  assign ck_wr_stat = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(STAT_ADDR));
  assign ck_wr_cfg  = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(CFG_ADDR));
  assign ck_rd_stat = bus_valid_i && !bus_write_i && (bus_addr_i == ADDR_W'(STAT_ADDR));

  AST_RESET_CLEARS: assert property (@(posedge clk_i) rst_i |=> (stat_q == 16'h0 && cfg_q == 16'h0 && !irq_o)); // R1
  AST_EVENT_STICKS: assert property (@(posedge clk_i) disable iff (rst_i) (ev_vec != 16'h0) |=> ((stat_q & $past(ev_vec)) == $past(ev_vec))); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (rst_i) ck_wr_stat |=> ((stat_q & $past(bus_wdata_i[15:0] & ~ev_vec)) == 16'h0)); // R3
  AST_UNDEF_ZERO: assert property (@(posedge clk_i) disable iff (rst_i) ck_rd_stat |-> ((bus_rdata_o & ~DATA_W'(16'h06F9)) == '0)); // R5
  AST_CFG_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i) !ck_wr_cfg |=> $stable(cfg_q)); // R6
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i) irq_o |-> ((stat_q & 16'h0601) != 16'h0)); // R7
  AST_ERR_NESTED: assert property (@(posedge clk_i) disable iff (rst_i) err_data_o |-> err_any_o); // R9
  AST_READY_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i) bus_valid_i |-> bus_ready_o); // R10
endmodule

bind sdh_stat_irq sdh_stat_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_ready_o(bus_ready_o),
  .bus_rdata_o(bus_rdata_o), .ev_vec(ev_vec), .stat_q(stat_q), .cfg_q(cfg_q),
  .irq_o(irq_o), .err_data_o(err_data_o), .err_any_o(err_any_o)
);

// File: tb/sdh_stat_irq_tb_top.sv
module sdh_stat_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0, write = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  logic [7:0]  ev = '0;
  logic        irq, c_wide, c_nib, c_slow, e_dat, e_any;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sdh_stat_irq dut_i (
    .clk_i(clk), .rst_i(rst), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_ready_o(ready), .bus_rdata_o(rdata),
    .ev_data_avail_i(ev[0]), .ev_fifo_err_i(ev[1]), .ev_crc7_err_i(ev[2]),
    .ev_crc16_err_i(ev[3]), .ev_cmd_tmo_i(ev[4]), .ev_dat_tmo_i(ev[5]),
    .ev_blk_done_i(ev[6]), .ev_busy_end_i(ev[7]),
    .irq_o(irq), .cfg_wide_o(c_wide), .cfg_nib_o(c_nib), .cfg_slow_o(c_slow),
    .err_data_o(e_dat), .err_any_o(e_any));

  function automatic int bitpos(int i);
    case (i)
      0: return 0;  1: return 3;  2: return 4;  3: return 5;
      4: return 6;  5: return 7;  6: return 9;  default: return 10;
    endcase
  endfunction

  function automatic logic [15:0] map_ev(logic [7:0] e);
    logic [15:0] m = '0;
    for (int i = 0; i < 8; i++) if (e[i]) m[bitpos(i)] = 1'b1;
    return m;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk); valid = 1'b0; write = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk); valid = 1'b1; write = 1'b0; addr = a;
    #1; d = rdata; rdy = ready;
    valid = 1'b0;
  endtask

  task automatic pulse(logic [7:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        r;
    logic [15:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_rd(4'd0, d, r); check(d == 0, "R1 status", d, 0);
    bus_rd(4'd1, d, r); check(d == 0, "R1 config", d, 0);
    check({irq, c_wide, c_nib, c_slow} == 0, "R1 outputs", {irq, c_wide, c_nib, c_slow}, 0);

    // R2 R3 R5 R9: all event subsets, sticky, partial clear
    for (int s = 0; s < 256; s++) begin
      pulse(8'(s));
      @(negedge clk);
      exp = map_ev(8'(s));
      bus_rd(4'd0, d, r); check(d == {16'h0, exp}, "R2 sticky set", d, {16'h0, exp});
      check(e_dat == |(exp & 16'h00B8), "R9 data error", e_dat, |(exp & 16'h00B8));
      check(e_any == |(exp & 16'h00F8), "R9 any error", e_any, |(exp & 16'h00F8));
      d = (s * 32'h9E37) ^ 32'hFFFF_F906;
      bus_wr(4'd0, d);
      exp = exp & ~d[15:0];
      bus_rd(4'd0, d, r); check(d == {16'h0, exp}, "R3 R5 partial clear", d, {16'h0, exp});
      bus_wr(4'd0, 32'h0000_FFFF);
      bus_rd(4'd0, d, r); check(d == 0, "R3 full clear", d, 0);
    end

    // R6 config bits and outputs
    bus_wr(4'd1, 32'hFFFF_FFFF);
    bus_rd(4'd1, d, r); check(d == 32'h051E, "R6 config mask", d, 32'h051E);
    for (int b = 1; b <= 3; b++) begin
      bus_wr(4'd1, 32'(1) << b);
      check({c_slow, c_nib, c_wide} == 3'(1 << (b - 1)), "R6 datapath bits",
            {c_slow, c_nib, c_wide}, 3'(1 << (b - 1)));
    end

    // R7 R8: enables x sources, with error flags also set
    for (int en = 0; en < 8; en++) begin
      for (int src = 0; src < 8; src++) begin
        logic [31:0] cw;
        logic        ex_irq;
        bus_wr(4'd0, 32'h0000_FFFF);
        bus_wr(4'd1, 32'h0);
        pulse({src[2], src[1], 5'b11111, src[0]});
        cw = {21'h0, en[2], 1'b0, en[1], 3'b0, en[0], 4'b0};
        bus_wr(4'd1, cw);
        ex_irq = (src[0] & en[0]) | (src[1] & en[1]) | (src[2] & en[2]);
        check(irq == ex_irq, "R7 R8 irq combine", irq, ex_irq);
      end
    end
    // R3: acknowledge sources clears irq
    bus_wr(4'd0, 32'h0000_0601);
    check(irq == 1'b0, "R3 ack drops irq", irq, 0);
    bus_rd(4'd0, d, r); check(d == 32'h00F8, "R3 errors kept", d, 32'h00F8);

    // R4 event vs clear same cycle
    bus_wr(4'd0, 32'h0000_FFFF);
    pulse(8'h01);
    @(negedge clk); ev = 8'h40; valid = 1'b1; write = 1'b1; addr = 4'd0; wdata = 32'h0000_0201;
    @(negedge clk); ev = '0; valid = 1'b0; write = 1'b0;
    bus_rd(4'd0, d, r); check(d == 32'h0200, "R4 event wins", d, 32'h0200);

    // R10 bus
    bus_wr(4'd1, 32'h0000_0010);
    bus_rd(4'd5, d, r); check(d == 0, "R10 unmapped read", d, 0);
    check(r == 1'b1, "R10 ready", r, 1);
    bus_wr(4'd5, 32'hFFFF_FFFF);
    bus_rd(4'd0, d, r); check(d == 32'h0200, "R10 unmapped write status", d, 32'h0200);
    bus_rd(4'd1, d, r); check(d == 32'h0010, "R10 unmapped write config", d, 32'h0010);
    @(negedge clk); #1;
    check(ready == 1'b0, "R10 idle not ready", ready, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule